// File: doc/BRIEF.md
# Sequence-Locked Freezable Controller

This block is a six-state controller whose state register can be frozen in place. It has no pin that requests the freeze. A watcher inside the block follows the 8-bit input bus. Once it has seen a fixed ordered run of four input words on back-to-back clock cycles, it raises an internal hold flag. That flag stays set until the next global reset. The unlock words use the upper nibble of the bus, which ordinary operation leaves at zero.

While hold is set, the controller's next-state logic keeps decoding the inputs on every cycle, so its combinational switching continues. Every state still resolves to a transition back to itself. The freeze is expressed inside the state graph and not as a separate load-enable mux:
- A state that already had a self-loop takes the OR of its own stay condition and hold.
- A state that always moved on (LOAD, DONE) gains a new self-loop guarded by hold.

The controller decodes four bits of the bus:
- bit 0: go
- bit 1: abort
- bit 2: more
- bit 3: ack

It presents a registered 3-bit code for its state.

Top module: `lockable_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller goes to IDLE, `state_code` becomes 3'b000, the hold flag clears and the unlock watcher returns to its first step.
- R2: Without hold, IDLE moves to ARM when go (din[0]) is 1 and otherwise stays. ARM moves to IDLE on abort (din[1]), else to LOAD on go, else stays; abort wins over go.
- R3: Without hold, LOAD always moves to RUN and DONE always moves to IDLE on the next edge.
- R4: Without hold, RUN stays while more (din[2]) is 1 and abort is 0, and otherwise moves to DRAIN. DRAIN moves to DONE when ack (din[3]) is 1 and otherwise stays.
- R5: `state_code` is registered and changes on the same edge as the state: IDLE=000, ARM=001, LOAD=011, RUN=010, DRAIN=110, DONE=111.
- R6: The hold flag sets at the edge that samples the fourth of the unlock words 8'hA5, 8'h3C, 8'hC3, 8'h5A, presented in that order on consecutive cycles. From the following edge on, the state no longer changes. The state transition at the setting edge itself still follows R2 to R4.
- R7: A word that does not match the expected next unlock word returns the watcher to its first step. If that word equals the first unlock word (8'hA5), it counts as a completed first step.
- R8: With hold set, the state stays the same for every input value, including states that have no ordinary self-loop (LOAD, DONE).
- R9: Once set, hold is unaffected by any input value. Only reset clears it, after which R2 to R4 apply again.
- R10: With hold set, a state that has its own stay condition stays even when its exit condition is present (for example, IDLE with go=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Input word. Bits 3:0 are the control bits; the whole word feeds the unlock watcher. |
| state_code | output | 3 | Registered code for the current state |

## Verification
A directed walk drives control-only words through every edge of the state graph, and a pseudo-random control-only stream covers mixed sequences. Both show the ordinary graph, and neither can unlock hold because the upper nibble stays zero.

Four unlock runs separate the watcher's behaviours:
- A run broken by a zero word must leave the controller free to move.
- A run with a doubled first word must still unlock, which shows the restart on the first word.
- A run ending in IDLE separates a widened self-loop from an exit.
- A run ending in DONE exercises the self-loop that hold adds to a state with none.

A full 256-value sweep under hold, followed by a reset, shows that hold is sticky and that only reset clears it.

// File: rtl/lockable_ctrl_pkg.sv
package lockable_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_LOAD  = 3'd2,
    ST_RUN   = 3'd3,
    ST_DRAIN = 3'd4,
    ST_DONE  = 3'd5
  } ctl_state_t;

  localparam int CTL_BITS = 4;
  localparam int B_GO     = 0;
  localparam int B_ABORT  = 1;
  localparam int B_MORE   = 2;
  localparam int B_ACK    = 3;

  function automatic logic [2:0] state_to_code(input ctl_state_t s);
    case (s)
      ST_IDLE:  state_to_code = 3'b000;
      ST_ARM:   state_to_code = 3'b001;
      ST_LOAD:  state_to_code = 3'b011;
      ST_RUN:   state_to_code = 3'b010;
      ST_DRAIN: state_to_code = 3'b110;
      ST_DONE:  state_to_code = 3'b111;
      default:  state_to_code = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/unlock_watch.sv
module unlock_watch #(
  parameter int W = 8,
  parameter int N = 4,
  parameter logic [N*W-1:0] SEQ = {8'h5A, 8'hC3, 8'h3C, 8'hA5}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] word_in,
  output logic         hold_q
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] step_q;
  logic [W-1:0]  expect_w;
  logic [W-1:0]  first_w;
  logic          hit;
  logic          hit_first;

  assign expect_w  = SEQ[step_q*W +: W];
  assign first_w   = SEQ[W-1:0];
  assign hit       = (word_in == expect_w);
  assign hit_first = (word_in == first_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      hold_q <= 1'b0;
    end else if (!hold_q) begin
      if (hit) begin
        if (step_q == LAST) begin
          hold_q <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else if (hit_first) begin
        step_q <= IW'(1);
      end else begin
        step_q <= '0;
      end
    end
  end

  // R9: once set, hold never drops without reset
  p_hold_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> hold_q);

  // R6: final word of a matched run sets hold on the next edge
  p_unlock_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && step_q == LAST && word_in == SEQ[(N-1)*W +: W]) |=> hold_q);

  // R7: a word matching neither the expected nor the first entry restarts the run
  p_break_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && !hit && !hit_first) |=> (step_q == '0 && !hold_q));

endmodule

// File: rtl/ctrl_core.sv
module ctrl_core
  import lockable_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [CTL_BITS-1:0] ctl,
  input  logic                hold,
  output logic [2:0]          code_q
);
  ctl_state_t st_q, st_nxt;
  logic go, abort_i, more, ack;

  assign go      = ctl[B_GO];
  assign abort_i = ctl[B_ABORT];
  assign more    = ctl[B_MORE];
  assign ack     = ctl[B_ACK];

  // every state's stay arc is its own condition OR hold
  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_IDLE: begin
        if (!go || hold) st_nxt = ST_IDLE;
        else             st_nxt = ST_ARM;
      end
      ST_ARM: begin
        if ((!abort_i && !go) || hold) st_nxt = ST_ARM;
        else if (abort_i)              st_nxt = ST_IDLE;
        else                           st_nxt = ST_LOAD;
      end
      ST_LOAD: begin
        if (hold) st_nxt = ST_LOAD;
        else      st_nxt = ST_RUN;
      end
      ST_RUN: begin
        if ((more && !abort_i) || hold) st_nxt = ST_RUN;
        else                            st_nxt = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!ack || hold) st_nxt = ST_DRAIN;
        else              st_nxt = ST_DONE;
      end
      ST_DONE: begin
        if (hold) st_nxt = ST_DONE;
        else      st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      code_q <= 3'b000;
    end else begin
      st_q   <= st_nxt;
      code_q <= state_to_code(st_nxt);
    end
  end

  // R8: a sampled hold freezes the state register
  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(st_q));

  // R3: LOAD and DONE leave unconditionally without hold
  p_load_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOAD && !hold) |=> st_q == ST_RUN);
  p_done_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE && !hold) |=> st_q == ST_IDLE);

  // R5: output code tracks the state register
  p_code_match_r5: assert property (@(posedge clk) disable iff (rst)
    code_q == state_to_code(st_q));

endmodule

// File: rtl/lockable_ctrl.sv
module lockable_ctrl
  import lockable_ctrl_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 4,
  parameter logic [N*W-1:0] SEQ = {8'h5A, 8'hC3, 8'h3C, 8'hA5}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [2:0]   state_code
);
  logic hold_w;

  unlock_watch #(.W(W), .N(N), .SEQ(SEQ)) u_watch (
    .clk     (clk),
    .rst     (rst),
    .word_in (din),
    .hold_q  (hold_w)
  );

  ctrl_core u_core (
    .clk    (clk),
    .rst    (rst),
    .ctl    (din[CTL_BITS-1:0]),
    .hold   (hold_w),
    .code_q (state_code)
  );

endmodule

// File: tb/lockable_ctrl_test.sv
module lockable_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = 8'h00;
  logic [2:0] state_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_st = 0;
  bit m_hold = 0;
  int m_idx = 0;
  logic [7:0] useq [4] = '{8'hA5, 8'h3C, 8'hC3, 8'h5A};
  logic [2:0] codes [6] = '{3'b000, 3'b001, 3'b011, 3'b010, 3'b110, 3'b111};

  lockable_ctrl uut (.clk(clk), .rst(rst), .din(din), .state_code(state_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int nxt(input int s, input logic [7:0] v, input bit h);
    bit go, ab, mo, ak;
    go = v[0]; ab = v[1]; mo = v[2]; ak = v[3];
    case (s)
      0: return (h || !go) ? 0 : 1;
      1: return (h || (!ab && !go)) ? 1 : (ab ? 0 : 2);
      2: return h ? 2 : 3;
      3: return (h || (mo && !ab)) ? 3 : 4;
      4: return (h || !ak) ? 4 : 5;
      default: return h ? 5 : 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: state_code=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] v, input string tag);
    @(negedge clk) din = v;
    @(posedge clk);
    m_st = nxt(m_st, v, m_hold);
    if (!m_hold) begin
      if (v == useq[m_idx]) begin
        if (m_idx == 3) begin m_hold = 1; m_idx = 0; end
        else m_idx++;
      end else m_idx = (v == useq[0]) ? 1 : 0;
    end
    #1 check(tag, state_code, codes[m_st]);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk) rst = 1'b1; din = 8'h00;
    @(posedge clk); @(posedge clk);
    #1;
    m_st = 0; m_hold = 0; m_idx = 0;
    check(tag, state_code, 3'b000);
    @(negedge clk) rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    // R1: reset state
    do_reset("R1 reset");
    // R2: IDLE/ARM arcs
    step(8'h00, "R2 idle stay");
    step(8'h01, "R2 idle go");
    step(8'h00, "R2 arm stay");
    step(8'h03, "R2 arm abort beats go");
    step(8'h01, "R2 idle go");
    step(8'h01, "R2 arm go");
    // R3: LOAD leaves unconditionally
    step(8'h00, "R3 load to run");
    // R4: RUN/DRAIN arcs
    step(8'h04, "R4 run more");
    step(8'h06, "R4 run abort");
    step(8'h00, "R4 drain stay");
    step(8'h08, "R4 drain ack");
    // R3: DONE leaves unconditionally
    step(8'h0F, "R3 done to idle");
    // R5: mixed control stream, codes follow every edge
    lf = 8'h1D;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step({4'h0, lf[3:0]}, "R5 control stream");
    end
    // R7: broken run must not unlock
    do_reset("R1 reset");
    step(8'hA5, "R7 broken run");
    step(8'h3C, "R7 broken run");
    step(8'h00, "R7 broken run");
    step(8'hC3, "R7 broken run");
    step(8'h5A, "R7 broken run");
    step(8'h01, "R7 still free after broken run");
    step(8'h01, "R7 still free after broken run");
    // R6/R10: unlock ending in IDLE, go must not leave
    do_reset("R1 reset");
    step(8'hA5, "R6 unlock");
    step(8'h3C, "R6 unlock");
    step(8'hC3, "R6 unlock");
    step(8'h5A, "R6 unlock edge follows graph");
    step(8'h01, "R10 idle stays with go under hold");
    step(8'h05, "R10 idle stays with go under hold");
    // R9: sweep every value under hold
    for (int v = 0; v < 256; v++) step(8'(v), "R9 hold sticky sweep");
    // R9: reset clears hold
    do_reset("R9 reset clears hold");
    step(8'h01, "R9 free after reset");
    // R7/R8: doubled first word restarts, freeze in DONE
    do_reset("R1 reset");
    step(8'hA5, "R7 restart on first word");
    step(8'hA5, "R7 restart on first word");
    step(8'h3C, "R7 restart on first word");
    step(8'hC3, "R7 restart on first word");
    step(8'h5A, "R6 unlock edge follows graph");
    step(8'h00, "R8 done frozen");
    for (int v = 0; v < 256; v++) step(8'(v), "R8 freeze sweep");
    check("R8 final code is DONE", state_code, 3'b111);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule